// File: doc/BRIEF.md
# Dual-Mode FIFO Read Output Stage

This block is the read half of a dual-clock FIFO. It owns the read pointer, the output data register and one active-low status pin whose meaning depends on a mode chosen at reset. In standard mode the pin is an empty indication, and a word reaches the output only when a read is requested. In fall-through mode the pin is a ready indication: the oldest stored word is moved to the output by itself, and each read discards the word on display.

The write pointer comes in from the write clock domain as a Gray code. It passes through a two-flop synchronizer and is then compared with the read pointer. Storage sits outside the block. The block presents a read address and takes back the word stored there through an asynchronous read. In standard mode the pin is driven from a registered status bit that sits behind the synchronizer. In fall-through mode the output register adds one more read-clock stage.

Top module: `rdstage_top`

## Requirements
- R1: While `rd_rst_n` is low at a rising `rd_clk` edge, the block clears `dout` to zero and the read pointer to zero. The pin goes low (empty) in standard mode and high (not ready) in fall-through mode.
- R2: The mode is captured from `fwft_sel` at reset edges (0 = standard, 1 = fall-through). Changes of `fwft_sel` outside reset have no effect.
- R3: In standard mode `flag_n` is high exactly when a word is available to read. After a Gray pointer change is applied, the pin rises at the third rising read-clock edge. It falls at the edge that reads the last word.
- R4: In standard mode, `rd_en` high with `flag_n` high at an edge loads the next word in write order into `dout` and advances the read pointer.
- R5: In standard mode, `rd_en` high while `flag_n` is low leaves the read pointer and `dout` unchanged.
- R6: In fall-through mode, a word written to an empty FIFO appears on `dout` with `flag_n` falling at the fourth rising edge after its Gray pointer change, with `rd_en` low.
- R7: In fall-through mode, while `flag_n` is low and `rd_en` is low, `flag_n` stays low and `dout` holds. This includes the last stored word.
- R8: In fall-through mode, `rd_en` high with `flag_n` low at an edge consumes the displayed word. The next word is loaded if one is stored. Otherwise `flag_n` goes high and `dout` keeps the word just consumed.
- R9: In fall-through mode, `rd_en` while `flag_n` is high has no effect. The next word written still appears in order.
- R10: Word order is preserved across read pointer wrap in both modes. The pointers are `AW+1` bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Synchronous active-low reset |
| fwft_sel | input | 1 | Mode select sampled during reset (1 = fall-through) |
| rd_en | input | 1 | Read request |
| wr_ptr_gray | input | AW+1 | Write pointer in Gray code from the write domain |
| rd_addr | output | AW | Storage read address |
| mem_rdata | input | DW | Word stored at `rd_addr` |
| dout | output | DW | Output data register |
| flag_n | output | 1 | Empty (standard) or not-ready (fall-through), active low |

## Verification
The bench counts the edges between a pointer change and the pin moving in each mode. A design that drops or adds a stage would move the pin one cycle early or late. It drains fall-through mode down to the last word, then keeps requesting. A design that clears the data, re-reads, or lets the pointer run past the writer would show a wrong or repeated word when the next write arrives. Reads aimed at an empty FIFO in standard mode would likewise corrupt the later sequence if they moved the pointer. Long mixed streams across pointer wrap would expose a faulty Gray decode or full-width compare as lost or duplicated words.

// File: rtl/rdstage_pkg.sv
// Shared types for the FIFO read output stage.
package rdstage_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/rdstage_ptr_sync.sv
// Carries a Gray-coded pointer into the local clock domain through a
// chain of STAGES flops and converts the result to binary.
// Assumes the source changes by at most one Gray step per source clock.
module rdstage_ptr_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: one synchronizer flop per stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else if (s == 0) stg[s] <= gray_in;
                else stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    // Purpose: Gray to binary decode of the last stage.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin_out[i] = ^(stg[STAGES-1] >> i);
        end
    end
endmodule

// File: rtl/rdstage_ptr_ctrl.sv
// Read pointer and registered "words available" bit.
// Assumes advance is only raised while words_q is high.
module rdstage_ptr_ctrl #(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        advance,
    input  logic [AW:0] wr_bin,
    output logic [AW:0] rptr,
    output logic        words_q
);
    logic [AW:0] rptr_nxt;

    // Purpose: next read pointer value.
    always_comb rptr_nxt = rptr + {{AW{1'b0}}, advance};

    // Purpose: pointer update and status register compared after the move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr    <= '0;
            words_q <= 1'b0;
        end else begin
            rptr    <= rptr_nxt;
            words_q <= (wr_bin != rptr_nxt);
        end
    end

    // R5, R9: the pointer never steps while no word is known to be stored
    a_r5_no_step_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> words_q);
endmodule

// File: rtl/rdstage_out_stage.sv
// Output data register and pin selection for both modes.
// Standard: loads on a request while words are available.
// Fall-through: loads whenever the register is free or being consumed.
module rdstage_out_stage #(
    parameter int DW = 36
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  rdstage_pkg::rd_mode_e  mode,
    input  logic                   words_q,
    input  logic                   rd_en,
    input  logic [DW-1:0]          mem_rdata,
    output logic                   advance,
    output logic [DW-1:0]          dout,
    output logic                   flag_n
);
    import rdstage_pkg::*;

    logic out_valid;

    // Purpose: decide whether a stored word moves into the output register.
    always_comb begin
        if (mode == MODE_FWFT) advance = words_q && (!out_valid || rd_en);
        else                   advance = words_q && rd_en;
    end

    // Purpose: output register and its valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout      <= '0;
            out_valid <= 1'b0;
        end else begin
            if (advance) dout <= mem_rdata;
            if (mode == MODE_FWFT) begin
                if (advance)    out_valid <= 1'b1;
                else if (rd_en) out_valid <= 1'b0;
            end else begin
                out_valid <= 1'b0;
            end
        end
    end

    // Purpose: pin meaning follows the mode.
    always_comb flag_n = (mode == MODE_FWFT) ? ~out_valid : words_q;

    // R1: reset clears the output register
    a_r1_reset_dout: assert property (@(posedge clk)
        !rst_n |=> (dout == '0));

    // R7: held word stays on display without a request
    a_r7_fwft_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FWFT && !flag_n && !rd_en) |=> (!flag_n && $stable(dout)));

    // R8: the last consumed word remains when the pin rises
    a_r8_fwft_keep_last: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FWFT && $rose(flag_n)) |-> $stable(dout));

    // R5: empty reads in standard mode leave the data alone
    a_r5_std_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STD && !flag_n) |=> $stable(dout));
endmodule

// File: rtl/rdstage_top.sv
// Read side of a dual-clock FIFO: synchronizes the write pointer,
// tracks the read pointer and drives the data register and the
// mode-dependent active-low pin. Storage is external with async read.
module rdstage_top #(
    parameter int DW = 36,
    parameter int AW = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          fwft_sel,
    input  logic          rd_en,
    input  logic [AW:0]   wr_ptr_gray,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] dout,
    output logic          flag_n
);
    import rdstage_pkg::*;

    localparam int PW = AW + 1;

    rd_mode_e      mode_q;
    logic [PW-1:0] wr_bin;
    logic [PW-1:0] rptr;
    logic          words_q;
    logic          advance;

    // Purpose: mode capture during reset only.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) mode_q <= fwft_sel ? MODE_FWFT : MODE_STD;
    end

    rdstage_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .gray_in (wr_ptr_gray),
        .bin_out (wr_bin)
    );

    rdstage_ptr_ctrl #(.AW(AW)) u_ptr (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .advance (advance),
        .wr_bin  (wr_bin),
        .rptr    (rptr),
        .words_q (words_q)
    );

    rdstage_out_stage #(.DW(DW)) u_out (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .mode      (mode_q),
        .words_q   (words_q),
        .rd_en     (rd_en),
        .mem_rdata (mem_rdata),
        .advance   (advance),
        .dout      (dout),
        .flag_n    (flag_n)
    );

    assign rd_addr = rptr[AW-1:0];

    // R1: pin state after a reset edge depends on the captured mode
    a_r1_reset_flag: assert property (@(posedge rd_clk)
        !rd_rst_n |=> (flag_n == $past(fwft_sel)));

    // R2: mode holds outside reset
    a_r2_mode_latched: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $past(rd_rst_n) |-> $stable(mode_q));

    // R5: standard empty reads keep the pointer
    a_r5_std_ptr_hold: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (mode_q == MODE_STD && !flag_n) |=> $stable(rptr));

    // R9: in fall-through the pointer moves only with a load that readies the pin
    a_r9_fwft_idle: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (mode_q == MODE_FWFT && flag_n) |=> ($stable(rptr) || !flag_n));
endmodule

// File: tb/sim_rdstage_top.sv
`timescale 1ns/1ps
module sim_rdstage_top;
    localparam int DW = 36;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fwft_sel = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW:0]   wptr = '0;
    logic [AW:0]   wr_gray;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] dout;
    logic          flag_n;
    logic [DW-1:0] mem [DEPTH];

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit fw_mode = 0;
    bit take_std = 0;
    bit take_fw = 0;
    logic [DW-1:0] exp_q [$];

    always #2.5 clk = ~clk;

    assign wr_gray   = wptr ^ (wptr >> 1);
    assign mem_rdata = mem[rd_addr];

    rdstage_top #(.DW(DW), .AW(AW), .SYNC_STAGES(2)) u0 (
        .rd_clk      (clk),
        .rd_rst_n    (rst_n),
        .fwft_sel    (fwft_sel),
        .rd_en       (rd_en),
        .wr_ptr_gray (wr_gray),
        .rd_addr     (rd_addr),
        .mem_rdata   (mem_rdata),
        .dout        (dout),
        .flag_n      (flag_n)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // driver side: store a word and publish the new pointer (no timing)
    task automatic put(input logic [DW-1:0] d);
        mem[wptr[AW-1:0]] = d;
        wptr = wptr + 1'b1;
        exp_q.push_back(d);
    endtask

    task automatic wr_word(input logic [DW-1:0] d);
        @(posedge clk); #1;
        put(d);
    endtask

    task automatic read_pulse;
        @(posedge clk); #1 rd_en = 1'b1;
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input bit m);
        @(posedge clk); #1;
        rst_n = 1'b0; fwft_sel = m; rd_en = 1'b0;
        wptr = '0; exp_q.delete(); take_std = 0; take_fw = 0; fw_mode = m;
        edges(1);
        chk("R1 flag", {63'd0, flag_n}, {63'd0, m});
        chk("R1 dout", 64'(dout), 64'd0);
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // monitor: scoreboard comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (!fw_mode) begin
                if (take_std) begin
                    if (exp_q.size() == 0) chk("R4/R10 underflow", 64'(dout), 64'hX);
                    else chk("R4/R10 std order", 64'(dout), 64'(exp_q.pop_front()));
                end
                take_std = rd_en && flag_n;
            end else begin
                if (take_fw && exp_q.size() != 0) void'(exp_q.pop_front());
                if (!flag_n) begin
                    if (exp_q.size() == 0) chk("R8/R10 extra word", 64'(dout), 64'hX);
                    else chk("R8/R10 fwft order", 64'(dout), 64'(exp_q[0]));
                end
                take_fw = rd_en && !flag_n;
            end
        end
    end

    task automatic stream(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); #1;
            if (exp_q.size() < 12 && ((i * 7) % 5) != 0)
                put({4'hA, 32'(i * 32'h01010101 + 32'h5)});
            rd_en = ((i * 3) % 4) != 0;
        end
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #1 rd_en = 1'b1;
        end
        @(posedge clk); #1 rd_en = 1'b0;
        edges(2);
        chk("R10 drained", 64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;

        // ---------------- standard mode ----------------
        do_reset(1'b0);
        @(posedge clk); #1 rd_en = 1'b1;
        repeat (4) @(posedge clk);
        #1 rd_en = 1'b0;
        edges(0);
        chk("R5 empty read flag", {63'd0, flag_n}, 64'd0);
        chk("R5 empty read dout", 64'(dout), 64'd0);

        wr_word(36'h1_1111_0001);
        edges(2);
        chk("R3 flag before third edge", {63'd0, flag_n}, 64'd0);
        edges(1);
        chk("R3 flag at third edge", {63'd0, flag_n}, 64'd1);
        read_pulse;
        edges(0);
        chk("R4 word read", 64'(dout), 64'h1_1111_0001);
        chk("R3 flag after last read", {63'd0, flag_n}, 64'd0);
        read_pulse;
        edges(0);
        chk("R5 dout kept on empty read", 64'(dout), 64'h1_1111_0001);

        // mode select toggled outside reset
        @(posedge clk); #1 fwft_sel = 1'b1;
        wr_word(36'h2_2222_0002);
        edges(5);
        chk("R2 no fall-through load", 64'(dout), 64'h1_1111_0001);
        chk("R2 standard flag", {63'd0, flag_n}, 64'd1);
        read_pulse;
        edges(0);
        chk("R2 read gives word", 64'(dout), 64'h2_2222_0002);

        stream(90);

        // ---------------- fall-through mode ----------------
        do_reset(1'b1);
        wr_word(36'h3_3333_0003);
        edges(3);
        chk("R6 not ready at third edge", {63'd0, flag_n}, 64'd1);
        edges(1);
        chk("R6 ready at fourth edge", {63'd0, flag_n}, 64'd0);
        chk("R6 first word shown", 64'(dout), 64'h3_3333_0003);
        wr_word(36'h4_4444_0004);
        edges(5);
        chk("R7 hold word", 64'(dout), 64'h3_3333_0003);
        chk("R7 hold flag", {63'd0, flag_n}, 64'd0);
        read_pulse;
        edges(0);
        chk("R8 next word", 64'(dout), 64'h4_4444_0004);
        chk("R8 flag stays low", {63'd0, flag_n}, 64'd0);
        edges(3);
        chk("R7 last word held", {63'd0, flag_n}, 64'd0);
        read_pulse;
        edges(0);
        chk("R8 flag rises", {63'd0, flag_n}, 64'd1);
        chk("R8 previous word kept", 64'(dout), 64'h4_4444_0004);
        @(posedge clk); #1 rd_en = 1'b1;
        repeat (3) @(posedge clk);
        #1 rd_en = 1'b0;
        edges(0);
        chk("R9 read ignored flag", {63'd0, flag_n}, 64'd1);
        chk("R9 read ignored dout", 64'(dout), 64'h4_4444_0004);
        wr_word(36'h5_5555_0005);
        edges(4);
        chk("R9 next word in order", 64'(dout), 64'h5_5555_0005);
        read_pulse;
        edges(1);

        stream(90);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule